// File: doc/BRIEF.md
# Configuration Stream Loader

The loader takes a configuration image from a host, one byte per write strobe, and passes its payload on to the configuration port of a programmable-logic target. The first sixteen bytes of every image form a header. Its first four bytes give the payload length as a big-endian number, most significant byte first. The other twelve header bytes carry metadata, which the loader discards. Once the header has arrived, the loader forwards exactly the stated number of payload bytes. Each forwarded byte is presented on `cfgData` together with a single-cycle `cfgClk` pulse. After the payload, the loader generates a fixed number of zero padding bytes by itself and then raises `done`.

The host marks the last byte of an image with `wrLast`. If an image ends before its header is complete, the loader rejects it. A failure reported by the target during a download is also latched. Both cases go to the `err` flag, which the host clears with `errClr`. The `restart` strobe returns the loader to its idle state, drops the error flag and sends a one-cycle reset pulse to the target.

The host must leave at least one idle cycle between two write strobes, so that each `cfgClk` pulse is followed by a low cycle. The loader has no back-pressure to enforce this.

Top module: `cfg_stream_loader`

## Requirements
- R1: After reset, `cfgClk`, `done`, `err` and `tgtRst` are all low.
- R2: Header bytes 0 to 3 form the payload length, with byte 0 as the most significant byte. None of the 16 header bytes is ever forwarded to `cfgData`.
- R3: Exactly the header-specified number of payload bytes is forwarded, in arrival order. Host bytes beyond that count are not forwarded.
- R4: Each forwarded byte appears on `cfgData` in the cycle after it is accepted, with `cfgClk` high for that one cycle. `cfgData` stays unchanged in the following cycle.
- R5: After the last payload byte, the loader sends five zero bytes, each with its own `cfgClk` pulse. `done` rises 12 cycles after the last payload byte is accepted.
- R6: A payload length of zero skips straight to padding. `done` rises 11 cycles after the 16th header byte is accepted.
- R7: If `wrLast` arrives with any of the first 15 header bytes, `err` is set and no `cfgClk` pulse is produced.
- R8: `tgtErr` seen during header, payload or padding sets `err` and stops forwarding. `err` stays set until `errClr` or `restart` is asserted.
- R9: Bytes written while `done` or `err` is set produce no `cfgClk` pulse.
- R10: `restart` gives a one-cycle `tgtRst` pulse in the following cycle and clears `done` and `err`. After that, a new image loads normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrValid | input | 1 | Host byte write strobe |
| wrData | input | 8 | Host byte |
| wrLast | input | 1 | Marks the final byte of an image |
| restart | input | 1 | Loader and target reset strobe |
| tgtErr | input | 1 | Failure indication from the target |
| errClr | input | 1 | Clears the error flag |
| cfgData | output | 8 | Configuration byte to the target |
| cfgClk | output | 1 | One pulse per configuration byte |
| tgtRst | output | 1 | Reset pulse to the target |
| done | output | 1 | Image fully loaded and padded |
| err | output | 1 | Latched error flag |

## Verification
Every forwarded byte is due on `cfgData`/`cfgClk` one cycle after the write is accepted. A monitor samples on the falling edge of each cycle with `cfgClk` high and pops the oldest expected byte from a queue that the driver fills. Any pulse that arrives while the queue is empty is therefore counted as a failure. The bench also checks the `done` latency exactly: 12 cycles after the last payload byte, or 11 cycles after the header for a zero-length image. It samples one cycle earlier to confirm `done` is still low and then at the due cycle. Errors are due one cycle after `wrLast` or `tgtErr`, and `tgtRst` one cycle after `restart`; each is sampled at the falling edge that follows.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  localparam int HDR_BYTES = 16;
  localparam int LEN_BYTES = 4;
  localparam int PAD_BYTES = 5;
  localparam int LEN_W     = 8 * LEN_BYTES;
  localparam int IDX_W     = $clog2(HDR_BYTES);
  localparam int PAD_W     = $clog2(PAD_BYTES + 1);

  typedef enum logic [2:0] {
    IDLE, HEADER, PAYLOAD, PAD, DONE, ERROR
  } loadState_t;

  typedef struct packed {
    logic clear;
    logic hdrTake;
    logic loadRem;
    logic emitData;
    logic emitPad;
  } ctlStrobes_t;
endpackage

// File: rtl/cfgl_dpath.sv
module cfgl_dpath
  import cfgl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      ctl,
  input  logic [7:0]       wrData,
  output logic [IDX_W-1:0] hdrIdx,
  output logic             lenZero,
  output logic             remOne,
  output logic             padFull,
  output logic [7:0]       cfgData,
  output logic             cfgClk
);
  logic [LEN_W-1:0] lenReg;
  logic [LEN_W-1:0] remCnt;
  logic [PAD_W-1:0] padCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrIdx  <= '0;
      lenReg  <= '0;
      remCnt  <= '0;
      padCnt  <= '0;
      cfgData <= '0;
      cfgClk  <= 1'b0;
    end else if (ctl.clear) begin
      hdrIdx  <= '0;
      lenReg  <= '0;
      remCnt  <= '0;
      padCnt  <= '0;
      cfgData <= '0;
      cfgClk  <= 1'b0;
    end else begin
      cfgClk <= 1'b0;
      if (ctl.hdrTake) begin
        hdrIdx <= hdrIdx + 1'b1;
        if (hdrIdx < IDX_W'(LEN_BYTES))
          lenReg <= {lenReg[LEN_W-9:0], wrData};
      end
      if (ctl.loadRem)
        remCnt <= lenReg;
      if (ctl.emitData) begin
        cfgData <= wrData;
        cfgClk  <= 1'b1;
        remCnt  <= remCnt - 1'b1;
      end
      if (ctl.emitPad) begin
        cfgData <= '0;
        cfgClk  <= 1'b1;
        padCnt  <= padCnt + 1'b1;
      end
    end
  end

  assign lenZero = (lenReg == '0);
  assign remOne  = (remCnt == LEN_W'(1));
  assign padFull = (padCnt == PAD_W'(PAD_BYTES));

  // R4: a configuration clock pulse lasts exactly one cycle
  a_r4_clk_single: assert property (@(posedge clk) disable iff (!rstN)
    cfgClk |=> !cfgClk);
  // R4: data is held through the cycle after the pulse
  a_r4_data_held: assert property (@(posedge clk) disable iff (!rstN)
    (cfgClk && !ctl.clear) |=> $stable(cfgData));
  // R3: the payload counter is never driven below zero
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    ctl.emitData |-> (remCnt != '0));
endmodule

// File: rtl/cfgl_ctrl.sv
module cfgl_ctrl
  import cfgl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic             wrLast,
  input  logic             restart,
  input  logic             tgtErr,
  input  logic             errClr,
  input  logic [IDX_W-1:0] hdrIdx,
  input  logic             lenZero,
  input  logic             remOne,
  input  logic             padFull,
  input  logic             cfgClk,
  output ctlStrobes_t      ctl,
  output logic             tgtRst,
  output logic             done,
  output logic             err
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_BYTES - 1);

  loadState_t state, nxt;
  logic errSet;

  always_comb begin
    nxt    = state;
    ctl    = '0;
    errSet = 1'b0;
    if (restart) begin
      ctl.clear = 1'b1;
      nxt       = IDLE;
    end else begin
      case (state)
        IDLE: if (wrValid) begin
          ctl.hdrTake = 1'b1;
          if (wrLast) begin
            nxt    = ERROR;
            errSet = 1'b1;
          end else nxt = HEADER;
        end
        HEADER: if (tgtErr) begin
          nxt    = ERROR;
          errSet = 1'b1;
        end else if (wrValid) begin
          ctl.hdrTake = 1'b1;
          if (hdrIdx == LAST_IDX) begin
            ctl.loadRem = 1'b1;
            nxt = lenZero ? PAD : PAYLOAD;
          end else if (wrLast) begin
            nxt    = ERROR;
            errSet = 1'b1;
          end
        end
        PAYLOAD: if (tgtErr) begin
          nxt    = ERROR;
          errSet = 1'b1;
        end else if (wrValid) begin
          ctl.emitData = 1'b1;
          if (remOne) nxt = PAD;
        end
        PAD: if (tgtErr) begin
          nxt    = ERROR;
          errSet = 1'b1;
        end else if (!cfgClk) begin
          if (padFull) nxt = DONE;
          else ctl.emitPad = 1'b1;
        end
        default: nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= IDLE;
      err    <= 1'b0;
      tgtRst <= 1'b0;
    end else begin
      state  <= nxt;
      tgtRst <= restart;
      if (restart)     err <= 1'b0;
      else if (errSet) err <= 1'b1;
      else if (errClr) err <= 1'b0;
    end
  end

  assign done = (state == DONE);

  // R9: no configuration pulse follows a cycle spent in DONE or ERROR
  a_r9_quiet_when_finished: assert property (@(posedge clk) disable iff (!rstN)
    (state == DONE || state == ERROR) |=> !cfgClk);
  // R8: the error flag holds until cleared or restarted
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (err && !errClr && !restart) |=> err);
  // R10: the target reset pulse always follows a restart strobe
  a_r10_rst_follows: assert property (@(posedge clk) disable iff (!rstN)
    tgtRst |-> $past(restart));
  // R5: done is only reached from padding
  a_r5_done_from_pad: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(state) == PAD));
endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
  import cfgl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  logic [7:0] wrData,
  input  logic       wrLast,
  input  logic       restart,
  input  logic       tgtErr,
  input  logic       errClr,
  output logic [7:0] cfgData,
  output logic       cfgClk,
  output logic       tgtRst,
  output logic       done,
  output logic       err
);
  ctlStrobes_t      ctl;
  logic [IDX_W-1:0] hdrIdx;
  logic             lenZero, remOne, padFull;

  cfgl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrLast(wrLast),
    .restart(restart), .tgtErr(tgtErr), .errClr(errClr),
    .hdrIdx(hdrIdx), .lenZero(lenZero), .remOne(remOne), .padFull(padFull),
    .cfgClk(cfgClk), .ctl(ctl), .tgtRst(tgtRst), .done(done), .err(err)
  );

  cfgl_dpath u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData),
    .hdrIdx(hdrIdx), .lenZero(lenZero), .remOne(remOne), .padFull(padFull),
    .cfgData(cfgData), .cfgClk(cfgClk)
  );
endmodule

// File: tb/tb_cfg_stream_loader.sv
module tb_cfg_stream_loader;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic wrValid = 1'b0, wrLast = 1'b0, restart = 1'b0, tgtErr = 1'b0, errClr = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] cfgData;
  logic cfgClk, tgtRst, done, err;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [7:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_stream_loader dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData), .wrLast(wrLast),
    .restart(restart), .tgtErr(tgtErr), .errClr(errClr),
    .cfgData(cfgData), .cfgClk(cfgClk), .tgtRst(tgtRst), .done(done), .err(err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: every pulse is compared against the oldest expected byte (R3, R4, R5)
  always @(negedge clk) begin
    if (rstN && cfgClk) begin
      if (expQ.size() == 0) check(1'b0, "R9 unexpected cfgClk pulse", cfgData, 0);
      else begin
        logic [7:0] e;
        e = expQ.pop_front();
        check(cfgData == e, "R3 forwarded byte", cfgData, e);
      end
    end
  end

  task automatic sendByte(input logic [7:0] b, input bit last);
    @(negedge clk);
    wrValid = 1'b1; wrData = b; wrLast = last;
    @(negedge clk);
    wrValid = 1'b0; wrLast = 1'b0;
    @(negedge clk);
  endtask

  task automatic sendHeader(input int unsigned len);
    sendByte(len[31:24], 1'b0);
    sendByte(len[23:16], 1'b0);
    sendByte(len[15:8], 1'b0);
    sendByte(len[7:0], 1'b0);
    for (int i = 0; i < 12; i++) sendByte(8'hC0 + 8'(i), 1'b0);
  endtask

  function automatic logic [7:0] payVal(input int i);
    return 8'((i * 7 + 3) & 8'hFF);
  endfunction

  // R5/R6: full image with exact done latency
  task automatic sendImage(input int unsigned len);
    sendHeader(len);
    for (int i = 0; i < int'(len); i++) begin
      expQ.push_back(payVal(i));
      sendByte(payVal(i), 1'b0);
    end
    for (int i = 0; i < 5; i++) expQ.push_back(8'h00);
    repeat ((len == 0) ? 9 : 10) @(negedge clk);
    check(done == 1'b0, (len == 0) ? "R6 done early" : "R5 done early", done, 0);
    @(negedge clk);
    check(done == 1'b1, (len == 0) ? "R6 done due" : "R5 done due", done, 1);
    check(expQ.size() == 0, "R5 pad bytes all sent", expQ.size(), 0);
  endtask

  task automatic doRestart();
    @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    check(tgtRst == 1'b1, "R10 tgtRst pulse", tgtRst, 1);
    check(done == 1'b0 && err == 1'b0, "R10 flags cleared", {done, err}, 0);
    @(negedge clk);
    check(tgtRst == 1'b0, "R10 tgtRst single cycle", tgtRst, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!cfgClk && !done && !err && !tgtRst, "R1 reset state",
          {cfgClk, done, err, tgtRst}, 0);

    // R2/R3/R4/R5: short payload, metadata never forwarded
    sendImage(3);
    // R9: extra bytes in DONE are ignored (monitor flags any pulse)
    sendByte(8'h77, 1'b0);
    sendByte(8'h88, 1'b1);
    check(done == 1'b1 && !cfgClk, "R9 done holds after extra bytes", done, 1);

    // R10 then R2: multi-byte big-endian length 0x0102
    doRestart();
    sendImage(32'h0000_0102);

    // R6: zero length
    doRestart();
    sendImage(0);

    // R7: image ending inside the header
    doRestart();
    for (int i = 0; i < 9; i++) sendByte(8'h00, 1'b0);
    sendByte(8'h00, 1'b1);
    check(err == 1'b1, "R7 short image error", err, 1);
    check(expQ.size() == 0, "R7 no pulses", expQ.size(), 0);
    // R9: bytes in ERROR ignored
    sendByte(8'h5A, 1'b0);
    check(err == 1'b1 && !done, "R9 error holds", err, 1);
    // R8: errClr
    @(negedge clk); errClr = 1'b1;
    @(negedge clk); errClr = 1'b0;
    check(err == 1'b0, "R8 errClr clears", err, 0);

    // R8: target error mid-payload stops forwarding
    doRestart();
    sendHeader(6);
    for (int i = 0; i < 2; i++) begin
      expQ.push_back(payVal(i));
      sendByte(payVal(i), 1'b0);
    end
    @(negedge clk); tgtErr = 1'b1;
    @(negedge clk); tgtErr = 1'b0;
    check(err == 1'b1, "R8 target error latched", err, 1);
    sendByte(payVal(2), 1'b0);
    sendByte(payVal(3), 1'b0);
    check(err == 1'b1 && !done, "R8 forwarding stopped", err, 1);
    check(expQ.size() == 0, "R8 only early bytes sent", expQ.size(), 0);
    @(negedge clk); errClr = 1'b1;
    @(negedge clk); errClr = 1'b0;
    check(err == 1'b0, "R8 errClr after target error", err, 0);

    // R10: loader usable again after error
    doRestart();
    sendImage(2);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule